// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus (I2C/SMBus style). It gives an external host access to a bank of 8-bit registers through an internal pointer. The SCL and SDA lines are oversampled on the system clock. The block synchronises them and detects clock edges and START/STOP conditions. It drives SDA only through an open-drain enable, which pulls the line low while it is set.

A transaction opens with an address byte. Its upper four bits are a build-time constant and its next three bits come from three select pins. A host writes by sending a pointer byte and then data bytes. Each data byte goes to the location the pointer names. A host reads in two steps. First it sends a write transaction that holds only the pointer byte, then a STOP. Then it starts a new transaction with the read bit set, and the slave sends one byte or more from the pointer. The pointer keeps its value across STOP and steps by one after every data byte. The register file sits outside the block and is reached through a plain port: an address, write data with a one-cycle strobe, and read data that follows the address combinationally.

Top module: `ptrslv_top`

## Requirements
- R1: The slave acknowledges an address byte, by holding SDA low during the ninth SCL pulse, only when its bits 7..4 equal the parameter ADDR_HI (default 4'b0101) and its bits 3..1 equal the select pins. Bit 0 of that byte is the direction: 0 means write and 1 means read.
- R2: In a write transaction, the slave acknowledges the byte that follows an accepted address and loads it into the pointer.
- R3: Each later data byte of a write is received MSB first and acknowledged on the ninth pulse. When it completes, it is written to the register named by the pointer through a one-cycle strobe. SDA is changed by the slave only while SCL is low, apart from an abort.
- R4: After each data byte, written or read, the pointer advances by one modulo 256, so the second byte of a word goes to or comes from pointer+1 (address 0xFF is followed by 0x00).
- R5: After an accepted read address, the slave sends the register at the pointer MSB first. If the master acknowledges, it sends the next register. If the master leaves SDA high on the ninth pulse, the slave releases SDA and waits for the next START.
- R6: The pointer keeps its value across STOP. A read transaction that sends no pointer byte starts at the pointer left by the earlier transaction.
- R7: After an address that does not match, the slave acknowledges nothing, writes nothing, leaves the pointer unchanged and keeps SDA released until the next START or STOP.
- R8: A START or STOP that arrives partway through a byte abandons that byte without writing a register. A START always begins a new address phase.
- R9: After reset, SDA is released, the pointer is 0 and the write strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 3 | Select pins forming address bits 3..1 |
| sda_oe_o | output | 1 | High pulls SDA low (open drain) |
| reg_addr_o | output | 8 | Current pointer, register file address |
| reg_wdata_o | output | 8 | Byte to be written |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register contents at reg_addr_o |

## Verification
The bench builds the block with ADDR_HI at its default 4'b0101 and with SYNC_STAGES raised to 3. The extra stage brings the slave's reaction time close to the bench's quarter bit period. Even so, acknowledge and read data still have to be on the line before the master raises SCL, which exercises the timing margin of the edge detectors. The select pins are held at 3'b101, so a mismatch in either the fixed nibble or the pin bits can be presented separately. Random pointers include the 0xFF wrap.

// File: rtl/ptrslv_pkg.sv
package ptrslv_pkg;
  parameter int DW = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_AACK_W, ST_AACK_R, ST_PTR, ST_PACK,
    ST_WDAT, ST_DACK, ST_RDAT, ST_RACK, ST_SKIP
  } slv_state_e;

  // Address byte layout: [7:4] fixed nibble, [3:1] select pins, [0] direction
  function automatic logic addr_match(input logic [DW-1:0] b,
                                      input logic [3:0] hi,
                                      input logic [2:0] sel);
    return (b[7:4] == hi) && (b[3:1] == sel);
  endfunction

  function automatic logic [DW-1:0] ptr_next(input logic [DW-1:0] p);
    return p + {{(DW-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/ptrslv_linesync.sv
module ptrslv_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_sr[STAGES-1];
      sda_p  <= sda_sr[STAGES-1];
    end
  end

  assign scl_lvl  = scl_sr[STAGES-1];
  assign sda_lvl  = sda_sr[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_p;
  assign scl_fall = ~scl_lvl & scl_p;
  assign start_ev = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/ptrslv_engine.sv
module ptrslv_engine
  import ptrslv_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [2:0]    addr_sel,
  input  logic [DW-1:0] rdata,
  output logic          sda_oe_o,
  output logic [DW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  slv_state_e    st_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q, tx_q, ptr_q;
  logic          mack_q;

  logic rx_state, byte_end, addr_hit;
  assign rx_state = (st_q == ST_ADDR) || (st_q == ST_PTR) || (st_q == ST_WDAT);
  assign byte_end = rx_state && scl_fall && (cnt_q == FULL);
  assign addr_hit = addr_match(sh_q, ADDR_HI, addr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      mack_q <= 1'b0;
    end else if (start_ev) begin
      st_q  <= ST_ADDR;
      cnt_q <= '0;
    end else if (stop_ev) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_ADDR, ST_PTR, ST_WDAT: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_q  <= {sh_q[DW-2:0], sda_lvl};
            cnt_q <= cnt_q + 1'b1;
          end
          if (byte_end) begin
            if (st_q == ST_ADDR)
              st_q <= !addr_hit ? ST_SKIP : (sh_q[0] ? ST_AACK_R : ST_AACK_W);
            else if (st_q == ST_PTR) begin
              ptr_q <= sh_q;
              st_q  <= ST_PACK;
            end else begin
              ptr_q <= ptr_next(ptr_q);
              st_q  <= ST_DACK;
            end
          end
        end
        ST_AACK_W: if (scl_fall) begin st_q <= ST_PTR;  cnt_q <= '0; end
        ST_PACK, ST_DACK: if (scl_fall) begin st_q <= ST_WDAT; cnt_q <= '0; end
        ST_AACK_R: if (scl_fall) begin
          tx_q  <= rdata;
          st_q  <= ST_RDAT;
          cnt_q <= '0;
        end
        ST_RDAT: begin
          if (scl_rise && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
          if (scl_fall) begin
            if (cnt_q == FULL) st_q <= ST_RACK;
            else tx_q <= {tx_q[DW-2:0], 1'b0};
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_lvl;
            ptr_q  <= ptr_next(ptr_q);
          end
          if (scl_fall) begin
            if (mack_q) begin
              tx_q  <= rdata;
              st_q  <= ST_RDAT;
              cnt_q <= '0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_AACK_W, ST_AACK_R, ST_PACK, ST_DACK: sda_oe_o = 1'b1;
      ST_RDAT: sda_oe_o = ~tx_q[DW-1];
      default: sda_oe_o = 1'b0;
    endcase
  end

  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = sh_q;
  assign reg_we_o    = byte_end && (st_q == ST_WDAT);

  // R1 R7
  property no_ack_on_miss;
    @(posedge clk) disable iff (!rst_n)
      (byte_end && st_q == ST_ADDR && !addr_hit) |=> !sda_oe_o;
  endproperty
  addr_miss_noack_chk: assert property (no_ack_on_miss);

  // R3
  property sda_moves_scl_low;
    @(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe_o) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_lvl;
  endproperty
  sda_chg_scl_low_chk: assert property (sda_moves_scl_low);

  // R4
  property ptr_steps_after_write;
    @(posedge clk) disable iff (!rst_n)
      reg_we_o |=> (ptr_q == ptr_next($past(ptr_q)));
  endproperty
  ptr_step_chk: assert property (ptr_steps_after_write);

  // R5
  property nack_releases;
    @(posedge clk) disable iff (!rst_n)
      (st_q == ST_RACK && scl_fall && !mack_q && !start_ev && !stop_ev)
        |=> (st_q == ST_IDLE && !sda_oe_o);
  endproperty
  nack_release_chk: assert property (nack_releases);

  // R6
  property ptr_kept_on_stop;
    @(posedge clk) disable iff (!rst_n)
      stop_ev |=> $stable(ptr_q);
  endproperty
  ptr_keep_chk: assert property (ptr_kept_on_stop);

  // R8
  property start_restarts;
    @(posedge clk) disable iff (!rst_n)
      start_ev |=> (st_q == ST_ADDR && cnt_q == '0 && !reg_we_o);
  endproperty
  start_restart_chk: assert property (start_restarts);
endmodule

// File: rtl/ptrslv_top.sv
module ptrslv_top
  import ptrslv_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b0101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    addr_sel_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  input  logic [DW-1:0] reg_rdata_i
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;

  ptrslv_linesync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  ptrslv_engine #(.ADDR_HI(ADDR_HI)) eng_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_lvl     (scl_lvl),
    .sda_lvl     (sda_lvl),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_ev    (start_ev),
    .stop_ev     (stop_ev),
    .addr_sel    (addr_sel_i),
    .rdata       (reg_rdata_i),
    .sda_oe_o    (sda_oe_o),
    .reg_addr_o  (reg_addr_o),
    .reg_wdata_o (reg_wdata_o),
    .reg_we_o    (reg_we_o)
  );
endmodule

// File: tb/ptrslv_top_tb_top.sv
module ptrslv_top_tb_top;
  localparam int Q = 8;
  localparam logic [3:0] HI = 4'b0101;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda_lo = 1'b0;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] rf [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr;
  wire sda_bus = ~(m_sda_lo | sda_oe);
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  ptrslv_top #(.ADDR_HI(HI), .SYNC_STAGES(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_sel_i(SEL), .sda_oe_o(sda_oe), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) rf[i] <= init_val(i);
    end else if (reg_we) begin
      rf[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = rf[reg_addr];

  function automatic logic [7:0] addr_byte(input logic [3:0] hi, input logic [2:0] s,
                                           input logic rd);
    return {hi, s, rd};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda_lo = 1'b0; wq();
    m_scl = 1'b1;    wq();
    m_sda_lo = 1'b1; wq();
    m_scl = 1'b0;    wq();
  endtask

  task automatic bus_stop();
    m_sda_lo = 1'b1; wq();
    m_scl = 1'b1;    wq();
    m_sda_lo = 1'b0; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda_lo = ~b; wq();
    m_scl = 1'b1;  wq(); wq();
    m_scl = 1'b0;  wq();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda_lo = 1'b0; wq();
    m_scl = 1'b1;    wq();
    ack = ~sda_bus;  wq();
    m_scl = 1'b0;    wq();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_sda_lo = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq();
      m_scl = 1'b1; wq();
      b[i] = sda_bus; wq();
      m_scl = 1'b0; wq();
    end
    put_bit(~give_ack);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bit a0, a1;
    bus_start();
    put_byte(addr_byte(HI, SEL, 1'b0), a0);
    put_byte(p, a1);
    bus_stop();
    chk(a0 && a1, "R2 pointer byte acked", {a0, a1}, 2'b11);
    exp_ptr = p;
  endtask

  task automatic write_word(input logic [7:0] p, input logic [7:0] d0, input logic [7:0] d1);
    bit a0, a1, a2, a3;
    bus_start();
    put_byte(addr_byte(HI, SEL, 1'b0), a0);
    put_byte(p, a1);
    put_byte(d0, a2);
    put_byte(d1, a3);
    bus_stop();
    chk(a0, "R1 address acked", a0, 1);
    chk(a1, "R2 pointer acked", a1, 1);
    chk(a2 && a3, "R3 data bytes acked", {a2, a3}, 2'b11);
    exp_mem[p] = d0;
    exp_mem[8'(p + 8'd1)] = d1;
    exp_ptr = 8'(p + 8'd2);
    chk(rf[p] == d0, "R3 first byte stored", rf[p], d0);
    chk(rf[8'(p + 8'd1)] == d1, "R4 second byte at pointer+1", rf[8'(p + 8'd1)], d1);
  endtask

  task automatic read_n(input int n, input string tag);
    bit a0;
    logic [7:0] d;
    bus_start();
    put_byte(addr_byte(HI, SEL, 1'b1), a0);
    chk(a0, "R1 read address acked", a0, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      chk(d == exp_mem[exp_ptr], tag, d, exp_mem[exp_ptr]);
      exp_ptr = 8'(exp_ptr + 8'd1);
    end
    wq();
    chk(!sda_oe, "R5 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit a0, a1, a2;
    logic [7:0] p, d0, d1;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    exp_ptr = 8'h00;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R9 reset state
    chk(!sda_oe, "R9 SDA released", sda_oe, 0);
    chk(reg_addr == 8'h00, "R9 pointer zero", reg_addr, 0);
    chk(!reg_we, "R9 no strobe", reg_we, 0);

    // Directed word write and read-backs
    write_word(8'h10, 8'hA5, 8'h3C);
    set_ptr(8'h10);
    read_n(1, "R5 one-byte read");
    set_ptr(8'h10);
    read_n(2, "R5 two-byte read");

    // R6 pointer retained across STOP: no pointer byte sent
    set_ptr(8'h20);
    read_n(2, "R4 read increments");
    read_n(1, "R6 read continues from kept pointer");

    // R4 wrap at 0xFF
    write_word(8'hFF, 8'h81, 8'h42);
    set_ptr(8'hFF);
    read_n(2, "R4 read wraps to 0x00");

    // R7 wrong fixed nibble, then wrong select pins
    set_ptr(8'h50);
    bus_start();
    put_byte(addr_byte(4'b0110, SEL, 1'b0), a0);
    put_byte(8'h40, a1);
    put_byte(8'h77, a2);
    bus_stop();
    chk(!a0 && !a1 && !a2, "R7 nibble mismatch not acked", {a0, a1, a2}, 0);
    bus_start();
    put_byte(addr_byte(HI, 3'b100, 1'b0), a0);
    put_byte(8'h41, a1);
    put_byte(8'h66, a2);
    bus_stop();
    chk(!a0 && !a1 && !a2, "R7 pin mismatch not acked", {a0, a1, a2}, 0);
    chk(rf[8'h40] == exp_mem[8'h40], "R7 no write at 0x40", rf[8'h40], exp_mem[8'h40]);
    chk(rf[8'h41] == exp_mem[8'h41], "R7 no write at 0x41", rf[8'h41], exp_mem[8'h41]);
    read_n(1, "R7 pointer unchanged by ignored traffic");

    // R8 STOP partway through a data byte
    bus_start();
    put_byte(addr_byte(HI, SEL, 1'b0), a0);
    put_byte(8'h30, a1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_stop();
    exp_ptr = 8'h30;
    chk(rf[8'h30] == exp_mem[8'h30], "R8 aborted byte not written", rf[8'h30], exp_mem[8'h30]);
    read_n(1, "R8 pointer after aborted write");

    // R8 repeated START partway through the pointer byte
    set_ptr(8'h60);
    bus_start();
    put_byte(addr_byte(HI, SEL, 1'b0), a0);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    read_n(2, "R8 repeated START restarts address phase");

    // Constrained random word writes with one- or two-byte read-backs
    for (int it = 0; it < 12; it++) begin
      p  = 8'($urandom);
      if (it == 3) p = 8'hFF;
      d0 = 8'($urandom);
      d1 = 8'($urandom);
      write_word(p, d0, d1);
      set_ptr(p);
      if ($urandom % 2 == 0) read_n(1, "R5 random one-byte read");
      else read_n(2, "R4 random two-byte read");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule